// File: doc/BRIEF.md
# Capture/Compare Timer with IR Carrier Gating

This block is a general-purpose up-counter that drives five capture/compare channels. The counter counts from zero up to a programmable period value and then wraps back to zero. It advances on the ticks of a four-step clock divider, or, in infrared mode, once for each period of an external carrier timer. Each channel is set up on its own. It can capture the count on edges of its input pin, pulse its output when the count equals its value register, or produce a pulse-width-modulated waveform.

In infrared mode every channel output is ANDed with the carrier. A PWM channel then emits bursts of carrier whose lengths are counted in whole carrier periods, which is the usual envelope of a consumer remote-control signal. Software reaches all settings through a small register port with a one-cycle read latency. Sticky event flags, combined into a single interrupt line, report captures, matches and wraps.

Top module: `ir_cc_timer`

## Requirements
- R1: The counter steps by one on each tick and returns to 0 on the tick after it reaches the PERIOD value (address 1), so a period value P gives P+1 counts. The count can be read and loaded at address 2.
- R2: The control register (address 0) selects the tick divider in bits [1:0] (0: every clock, 1: every 8, 2: every 32, 3: every 128). Bit 2 enables counting. While bit 2 is 0 the count holds.
- R3: When control bit 3 is set, the counter ticks once per rising edge of `carrier_in` and ignores the divider. With the carrier idle, the count holds.
- R4: When control bit 3 is set, each channel output equals the channel's level AND the carrier, seen two clocks late. The output is low in every cycle that follows a low carrier sample.
- R5: A channel in capture mode (config bits [1:0] = 1, config at address 4+2i, value at 5+2i) copies the count into its value register on a rising edge of `cap_in[i]` if config bit 2 is set, and on a falling edge if config bit 3 is set. Edges that are not selected leave the value and the flags unchanged. The input passes a 2-stage synchronizer first.
- R6: In PWM mode (config 3) with value C, the output goes high at the wrap and low when the count equals C. It is high for C of every P+1 counts, constantly low for C = 0, and constantly high for C > P.
- R7: In match mode (config 2) the output is high for the one count in which the count equals the value register. If the value is greater than P the output stays low. Mode 0 keeps the output low.
- R8: FLAGS (address 3) holds sticky bits. Bit i is set by a capture or match on channel i, and bit 5 is set by a counter wrap. Writing a 1 clears a bit, but a new event in the same cycle takes precedence over the clear.
- R9: `irq` is a registered OR of the flags.
- R10: After reset all registers read 0 and all outputs are low. A read returns data on `reg_rdata` one clock after `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one clock after the read strobe |
| cap_in | input | 5 | Capture inputs, one per channel |
| carrier_in | input | 1 | Carrier waveform from another timer |
| ch_out | output | 5 | Registered channel outputs |
| irq | output | 1 | Event interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, five channels, a 4-bit address and a 7-bit divider. Every divider setting is therefore exercised, including the 128-clock tick, since short periods keep one full counter cycle at a few hundred clocks. Because all five channels are present, capture, PWM and match channels can run side by side on one counter. The 16-bit width makes arbitrary random capture values visible at the read port.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    CH_OFF     = 2'd0,
    CH_CAPTURE = 2'd1,
    CH_MATCH   = 2'd2,
    CH_PWM     = 2'd3
  } ch_mode_e;

  localparam int unsigned ADDR_CTRL    = 0;
  localparam int unsigned ADDR_PERIOD  = 1;
  localparam int unsigned ADDR_COUNT   = 2;
  localparam int unsigned ADDR_FLAGS   = 3;
  localparam int unsigned ADDR_CH_BASE = 4;
endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int PS_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] div_cnt;
  logic [PS_W-1:0] lim;

  always_comb begin
    case (sel)
      2'd0:    lim = PS_W'(0);
      2'd1:    lim = PS_W'(7);
      2'd2:    lim = PS_W'(31);
      default: lim = PS_W'(127);
    endcase
  end

  assign tick = en && (div_cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart || !en)
      div_cnt <= '0;
    else if (div_cnt == lim)
      div_cnt <= '0;
    else
      div_cnt <= div_cnt + 1'b1;
  end

  // R2: divider never runs past the selected limit
  p_div_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (!restart && en) |=> (div_cnt <= lim || $past(sel) != sel));
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ir_mode,
  input  logic             presc_tick,
  input  logic             carrier_in,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next,
  output logic             tick,
  output logic             wrap,
  output logic             carrier_lvl
);
  logic car_q, car_qq, car_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q  <= 1'b0;
      car_qq <= 1'b0;
    end else begin
      car_q  <= carrier_in;
      car_qq <= car_q;
    end
  end

  assign car_rise    = car_q && !car_qq;
  assign carrier_lvl = car_q;
  assign tick        = run && (ir_mode ? car_rise : presc_tick);
  assign wrap        = tick && (cnt >= period);
  assign cnt_next    = wrap ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt_next;
  end

  // R1: single step per tick
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap && !load) |=> cnt == $past(cnt) + 1'b1);
  // R1: wrap returns to zero
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (wrap && !load) |=> cnt == '0);
  // R2: counter frozen while disabled
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/tc_channel.sv
module tc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tc_pkg::ch_mode_e mode,
  input  logic [1:0]       edge_sel,
  input  logic             ir_mode,
  input  logic             carrier_lvl,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             val_we,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic             cap_in,
  output logic [CNT_W-1:0] val,
  output logic             out,
  output logic             evt
);
  import tc_pkg::*;

  logic s1, s2, s3;
  logic rise, fall, cap_evt, match_evt, hit;
  logic level, level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= cap_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise      = s2 && !s3;
  assign fall      = !s2 && s3;
  assign cap_evt   = (mode == CH_CAPTURE) && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
  assign hit       = (cnt_next == val);
  assign match_evt = tick && hit && (mode == CH_MATCH || mode == CH_PWM);
  assign evt       = cap_evt || match_evt;

  always_comb begin
    level_d = level;
    case (mode)
      CH_PWM: begin
        if (val == '0)       level_d = 1'b0;
        else if (tick && hit) level_d = 1'b0;
        else if (wrap)       level_d = 1'b1;
      end
      CH_MATCH: if (tick) level_d = hit;
      default:  level_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val   <= '0;
      level <= 1'b0;
      out   <= 1'b0;
    end else begin
      if (cap_evt)     val <= cnt;
      else if (val_we) val <= val_wdata;
      level <= level_d;
      out   <= ir_mode ? (level_d && carrier_lvl) : level_d;
    end
  end

  // R5: captured value is the count at the selected edge
  p_capture_value_r5: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> val == $past(cnt));
  // R6: zero duty keeps the PWM output low
  p_pwm_zero_low_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_PWM && val == '0) |=> !out);
  // R4: a low carrier sample gates the output off
  p_ir_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (ir_mode && !carrier_lvl) |=> !out);
  // R7: idle channel stays low
  p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_OFF) |=> !out);
endmodule

// File: rtl/ir_cc_timer.sv
module ir_cc_timer #(
  parameter int CNT_W  = 16,
  parameter int NCH    = 5,
  parameter int ADDR_W = 4,
  parameter int PS_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic [NCH-1:0]    cap_in,
  input  logic              carrier_in,
  output logic [NCH-1:0]    ch_out,
  output logic              irq
);
  import tc_pkg::*;

  localparam int FW = NCH + 1;

  logic [1:0]       ps_sel_q;
  logic             run_q, ir_q;
  logic [CNT_W-1:0] period_q;
  logic [FW-1:0]    flags_q, flags_d, flag_set, flag_clr;

  logic             ctrl_we, period_we, count_we, flags_we;
  logic             presc_tick, ctr_tick, ctr_wrap, carrier_lvl;
  logic [CNT_W-1:0] cnt, cnt_next;
  logic [NCH-1:0]   ch_evt;

  ch_mode_e         ch_mode_q [NCH];
  logic [1:0]       ch_edge_q [NCH];
  logic [CNT_W-1:0] ch_val    [NCH];
  logic [CNT_W-1:0] rd_mux;

  assign ctrl_we   = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
  assign period_we = reg_we && (reg_addr == ADDR_W'(ADDR_PERIOD));
  assign count_we  = reg_we && (reg_addr == ADDR_W'(ADDR_COUNT));
  assign flags_we  = reg_we && (reg_addr == ADDR_W'(ADDR_FLAGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_sel_q <= 2'd0;
      run_q    <= 1'b0;
      ir_q     <= 1'b0;
      period_q <= '0;
    end else begin
      if (ctrl_we) begin
        ps_sel_q <= reg_wdata[1:0];
        run_q    <= reg_wdata[2];
        ir_q     <= reg_wdata[3];
      end
      if (period_we) period_q <= reg_wdata;
    end
  end

  tc_prescaler #(.PS_W(PS_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .en      (run_q),
    .restart (ctrl_we),
    .sel     (ps_sel_q),
    .tick    (presc_tick)
  );

  tc_counter #(.CNT_W(CNT_W)) u_ctr (
    .clk         (clk),
    .rst         (rst),
    .run         (run_q),
    .ir_mode     (ir_q),
    .presc_tick  (presc_tick),
    .carrier_in  (carrier_in),
    .load        (count_we),
    .load_val    (reg_wdata),
    .period      (period_q),
    .cnt         (cnt),
    .cnt_next    (cnt_next),
    .tick        (ctr_tick),
    .wrap        (ctr_wrap),
    .carrier_lvl (carrier_lvl)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cfg_we, val_we;
    assign cfg_we = reg_we && (reg_addr == ADDR_W'(ADDR_CH_BASE + 2*i));
    assign val_we = reg_we && (reg_addr == ADDR_W'(ADDR_CH_BASE + 2*i + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        ch_mode_q[i] <= CH_OFF;
        ch_edge_q[i] <= 2'b00;
      end else if (cfg_we) begin
        ch_mode_q[i] <= ch_mode_e'(reg_wdata[1:0]);
        ch_edge_q[i] <= reg_wdata[3:2];
      end
    end

    tc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk         (clk),
      .rst         (rst),
      .mode        (ch_mode_q[i]),
      .edge_sel    (ch_edge_q[i]),
      .ir_mode     (ir_q),
      .carrier_lvl (carrier_lvl),
      .tick        (ctr_tick),
      .wrap        (ctr_wrap),
      .cnt         (cnt),
      .cnt_next    (cnt_next),
      .val_we      (val_we),
      .val_wdata   (reg_wdata),
      .cap_in      (cap_in[i]),
      .val         (ch_val[i]),
      .out         (ch_out[i]),
      .evt         (ch_evt[i])
    );
  end

  assign flag_set = {ctr_wrap, ch_evt};
  assign flag_clr = flags_we ? reg_wdata[FW-1:0] : '0;
  assign flags_d  = (flags_q & ~flag_clr) | flag_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq     <= |flags_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL))   rd_mux = CNT_W'({ir_q, run_q, ps_sel_q});
    if (reg_addr == ADDR_W'(ADDR_PERIOD)) rd_mux = period_q;
    if (reg_addr == ADDR_W'(ADDR_COUNT))  rd_mux = cnt;
    if (reg_addr == ADDR_W'(ADDR_FLAGS))  rd_mux = CNT_W'(flags_q);
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == ADDR_W'(ADDR_CH_BASE + 2*i))     rd_mux = CNT_W'({ch_edge_q[i], ch_mode_q[i]});
      if (reg_addr == ADDR_W'(ADDR_CH_BASE + 2*i + 1)) rd_mux = ch_val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  // R8: a wrap always leaves its flag set, even against a clear
  p_wrap_flag_r8: assert property (@(posedge clk) disable iff (rst)
    ctr_wrap |=> flags_q[NCH]);
  // R8: flags only fall through a software clear
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (!flags_we) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R9: interrupt follows any pending flag
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
    (|flag_set) |=> irq);
endmodule

// File: tb/ir_cc_timer_bench.sv
module ir_cc_timer_bench;
  localparam int CW = 16;
  localparam int NC = 5;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic [NC-1:0] cap_in = '0;
  logic          carrier = 1'b0;
  logic          car_en = 1'b0;
  logic [NC-1:0] ch_out;
  logic          irq;

  int n_checks = 0;
  int n_err = 0;
  int ph = 0;

  always #4 clk = ~clk;

  ir_cc_timer u_ir_cc_timer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .carrier_in(carrier), .ch_out(ch_out), .irq(irq)
  );

  // carrier: period 4 clocks, high 2
  initial forever begin
    @(posedge clk);
    #2;
    if (car_en) begin
      ph = (ph + 1) % 4;
      carrier = (ph < 2);
    end else begin
      carrier = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = CW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_re = 1'b0;
    d = int'(reg_rdata);
  endtask

  task automatic count_high(input int ch, input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (ch_out[ch]) n++;
    end
  endtask

  function automatic int divv(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 8 : (sel == 2) ? 32 : 128;
  endfunction

  function automatic int pwm_exp(input int c, input int p, input int d);
    return ((c < p + 1) ? c : p + 1) * d;
  endfunction

  function automatic int match_exp(input int c, input int p, input int d);
    return (c <= p) ? d : 0;
  endfunction

  task automatic pwm_run(input int p, input int c, input int c2, input int sel);
    int d, n, v;
    d = divv(sel);
    wr(0, 0);
    wr(1, p);
    wr(2, 0);
    wr(6, 3); wr(7, c);
    wr(8, 2); wr(9, c2);
    wr(3, 63);
    wr(0, 4 | sel);
    repeat (2 * d * (p + 1) + 8) @(negedge clk);
    count_high(1, d * (p + 1), n);
    check("R6 pwm duty", n, pwm_exp(c, p, d));
    count_high(2, d * (p + 1), n);
    check("R7 match pulse", n, match_exp(c2, p, d));
    rd(3, v);
    check("R8 wrap flag", (v >> 5) & 1, 1);
    wr(0, 0);
    rd(2, v);
    check("R1 count within period", int'(v <= p), 1);
  endtask

  initial begin
    int v, n, cnt_a, cnt_b, p, c, sel, es, val0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    check("R10 outputs low", int'(ch_out), 0);
    check("R10 irq low", int'(irq), 0);
    rd(0, v); check("R10 ctrl zero", v, 0);
    rd(1, v); check("R10 period zero", v, 0);
    rd(3, v); check("R10 flags zero", v, 0);

    // R1/R2: load, readback, hold while stopped
    wr(2, 16'h1234);
    rd(2, v); check("R1 count load", v, 16'h1234);
    repeat (10) @(negedge clk);
    rd(2, v); check("R2 stopped count holds", v, 16'h1234);

    // R5: capture on rising edge
    wr(4, 1 | (1 << 2));
    cap_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(5, v); check("R5 rising capture", v, 16'h1234);
    rd(3, v); check("R8 channel flag", v & 1, 1);
    check("R9 irq on flag", int'(irq), 1);
    wr(3, 63);
    rd(3, v); check("R8 write-one clear", v, 0);
    @(negedge clk);
    check("R9 irq clears", int'(irq), 0);
    // R5: unselected falling edge ignored
    wr(2, 16'h0042);
    cap_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    rd(5, v); check("R5 falling ignored value", v, 16'h1234);
    rd(3, v); check("R5 falling ignored flag", v, 0);
    // R5: both edges
    wr(4, 1 | (3 << 2));
    cap_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(5, v); check("R5 both-edge capture", v, 16'h0042);

    // R5: random captures
    for (int k = 0; k < 6; k++) begin
      int cv;
      es = 1 + int'($urandom_range(2));
      cv = int'($urandom_range(16'hFFFF));
      wr(4, 1 | (es << 2));
      rd(5, val0);
      wr(2, cv);
      cap_in[0] = ~cap_in[0];
      repeat (5) @(negedge clk);
      rd(5, v);
      if ((cap_in[0] && (es & 1) != 0) || (!cap_in[0] && (es & 2) != 0))
        check("R5 random capture", v, cv);
      else
        check("R5 random edge ignored", v, val0);
    end
    wr(4, 0);

    // R6/R7/R2: directed corners
    pwm_run(5, 0, 0, 0);
    pwm_run(5, 9, 5, 0);
    pwm_run(4, 2, 7, 2);
    pwm_run(3, 1, 3, 3);
    // random
    for (int k = 0; k < 6; k++) begin
      p = 3 + int'($urandom_range(17));
      c = int'($urandom_range(p + 3));
      sel = int'($urandom_range(1));
      pwm_run(p, c, int'($urandom_range(p + 2)), sel);
    end

    // R3/R4: IR mode
    for (int k = 0; k < 4; k++) begin
      p = 2 + int'($urandom_range(6));
      c = 1 + int'($urandom_range(p - 1));
      wr(0, 0);
      wr(1, p);
      wr(2, 0);
      wr(6, 3); wr(7, c);
      car_en = 1'b1;
      wr(0, 8 | 4 | 3);
      repeat (8 * (p + 1) + 8) @(negedge clk);
      count_high(1, 4 * (p + 1), n);
      check("R4 ir gated burst", n, 2 * c);
    end
    car_en = 1'b0;
    repeat (6) @(negedge clk);
    rd(2, cnt_a);
    count_high(1, 20, n);
    check("R4 no carrier no output", n, 0);
    rd(2, cnt_b);
    check("R3 idle carrier holds count", cnt_b, cnt_a);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule